// File: doc/BRIEF.md
# ARINC 429 Transmit Channel

This block is one transmit lane of an avionics serial word transmitter. A host writes a 16-bit control word and queues 32-bit data words through a small register port. Each data word arrives as two 16-bit halves: the upper half is held in a staging register, and the lower half commits the full word to an eight-entry queue. The channel takes queued words one at a time and sends them on a two-wire bipolar return-to-zero pair. Each bit period has an active half, on one wire or the other, and then a null half. Bit 1 of the word (bit 0 of the lower half) goes out first.

Timing comes from an outside strobe, `half_tick`, that pulses once per half bit period. Between words the channel can leave a gap of 0 to 31 null bit periods. It can also replace the last bit of each word with an even or odd parity bit. The control word read-back reports the free queue space in its low nibble.

A flag rises when the last queued word has been fully sent. Once that happens, the host must take the enable bit low and then high again before the queue accepts new words.

Top module: `a429_tx_chan`

## Requirements
- R1: Register addresses are 0 = control, 1 = upper data half, 2 = lower data half, and 3 reads zero. After reset the control read-back is 0x0008, `eot` is 1 and both line outputs are low. Control bits 14..12 and 3..0 cannot be written and read 0 and free space respectively.
- R2: A write to address 1 stages the upper 16 bits. A write to address 2 queues {staged, written} as one 32-bit word, with written bit 0 sent first.
- R3: Control bits 3..0 read DEPTH minus the number of queued words. A lower-half write while the queue holds DEPTH words is dropped.
- R4: Each bit uses two `half_tick` periods. The first half drives `line_hi` for a 1 or `line_lo` for a 0, and the second half drives neither. The two lines are never high together.
- R5: Control bit 10 enables parity and bit 11 selects odd (1) or even (0). With parity on, sent bit 32 is replaced so that the 32 sent bits have the selected parity. With parity off, it is sent as written.
- R6: Control bits 9..5 give G. Consecutive queued words have G null bit periods between the null half of one word's last bit and the next word's first active half.
- R7: Clearing control bit 15 (enable) stops any word in progress. Both lines stay low while enable is 0.
- R8: A control write with bit 4 = 0 empties the queue. Lower-half writes are dropped while bit 4 reads 0.
- R9: A control write that takes both bit 15 and bit 4 from 1 to 0 is ignored entirely. `bad_wr` pulses high for one cycle after it.
- R10: After the last queued word finishes, lower-half writes are dropped until enable is written 0 and then 1.
- R11: `eot` goes high when a word finishes with the queue empty. It goes low when a word starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` (combinational) |
| half_tick | input | 1 | One-cycle strobe per half bit period |
| line_hi | output | 1 | Line high-side pulse |
| line_lo | output | 1 | Line low-side pulse |
| eot | output | 1 | End of transmission flag |
| bad_wr | output | 1 | One-cycle pulse on a rejected control write |

## Verification
The assertions assume that `half_tick` is a single-cycle strobe spaced at least two clocks apart. They also assume the host never writes the upper half and the lower half in the same cycle. The stimulus follows these assumptions: it generates the strobe from a fixed divider and issues one register write at a time through a task. Random words come from a seeded generator. Directed cases cover a full queue, a flush, a rejected write, an abort in mid-word and the re-arm rule. Parity settings and gap lengths change only once the line has drained, so each word's expected format is fixed when the word is queued.

// File: rtl/a429_pkg.sv
// Shared constants and types for the transmit channel.
// Assumes a 16-bit host port and 32-bit line words.
package a429_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_MSW  = 2'd1;
    localparam logic [1:0] ADDR_LSW  = 2'd2;

    localparam int EN_BIT   = 15;
    localparam int ODD_BIT  = 11;
    localparam int PAR_BIT  = 10;
    localparam int GAP_HI   = 9;
    localparam int GAP_LO   = 5;
    localparam int FIFO_BIT = 4;
    localparam int GAP_W    = GAP_HI - GAP_LO + 1;

    typedef struct packed {
        logic             en;
        logic             odd;
        logic             par;
        logic [GAP_W-1:0] gap;
        logic             fifo_on;
    } ctrl_t;

    typedef enum logic [1:0] {S_IDLE, S_SEND, S_GAP} ser_state_t;
endpackage

// File: rtl/a429_ctrl_regs.sv
// Control register, write filter, arming logic and upper-half staging.
// Assumes at most one host write per cycle. Produces the queue push and flush requests.
module a429_ctrl_regs
    import a429_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wr_data,
    input  logic        drained,
    output ctrl_t       ctrl,
    output logic        flush,
    output logic        push,
    output logic [31:0] push_word,
    output logic        bad_wr
);
    ctrl_t       nxt;
    logic        ctrl_wr;
    logic        illegal;
    logic        armed;
    logic [15:0] msw_q;
    logic        unused_bits;

    // Decode the proposed new control value from the write data.
    always_comb begin
        nxt.en      = wr_data[EN_BIT];
        nxt.odd     = wr_data[ODD_BIT];
        nxt.par     = wr_data[PAR_BIT];
        nxt.gap     = wr_data[GAP_HI:GAP_LO];
        nxt.fifo_on = wr_data[FIFO_BIT];
    end

    assign unused_bits = ^{wr_data[14:12], wr_data[3:0]};
    assign ctrl_wr   = wr_en && (addr == ADDR_CTRL);
    assign illegal   = ctrl_wr && ctrl.en && !nxt.en && ctrl.fifo_on && !nxt.fifo_on;
    assign flush     = ctrl_wr && !illegal && !nxt.fifo_on;
    assign push      = wr_en && (addr == ADDR_LSW) && ctrl.fifo_on && armed;
    assign push_word = {msw_q, wr_data};

    // Control register: accepts every write except the forbidden double clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (ctrl_wr && !illegal)
            ctrl <= nxt;
    end

    // Arming: set by an enable rise, dropped by an enable clear or a drained line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (ctrl_wr && !illegal) begin
            if (!nxt.en)
                armed <= 1'b0;
            else if (!ctrl.en)
                armed <= 1'b1;
        end else if (drained)
            armed <= 1'b0;
    end

    // Staging register for the upper data half.
    always_ff @(posedge clk) begin
        if (!rst_n)
            msw_q <= '0;
        else if (wr_en && addr == ADDR_MSW)
            msw_q <= wr_data;
    end

    // One-cycle pulse that reports a rejected control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bad_wr <= 1'b0;
        else
            bad_wr <= illegal;
    end

    // R9: a rejected write leaves the control register untouched.
    a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |-> $stable(ctrl));
endmodule

// File: rtl/a429_word_fifo.sv
// Synchronous word queue with flush. Pushes while full are dropped.
// Pops while empty are ignored. Data at the head is readable combinationally.
module a429_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    input  logic                       flush,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign do_push = push && (count < CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign head    = mem[rptr];

    // Pointer and occupancy bookkeeping; flush wins over everything.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push)
                wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wptr] <= push_data;
    end

    // R3: occupancy never exceeds the depth.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R3: a push into a full queue changes nothing.
    a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && count == CW'(DEPTH) && !pop && !flush) |=> count == CW'(DEPTH));
    // R8: a flush leaves the queue empty.
    a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0);
endmodule

// File: rtl/a429_serializer.sv
// Bit serializer: sends LSB first, two half-ticks per bit (active then null),
// then a programmable null gap. Assumes half_tick is a one-cycle strobe.
module a429_serializer
    import a429_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  ctrl_t             ctrl,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_head,
    output logic              pop,
    output logic              drained,
    output logic              line_hi,
    output logic              line_lo,
    output logic              eot
);
    localparam int BW = $clog2(WORD_W);
    localparam int GW = GAP_W + 1;

    ser_state_t        state;
    logic [WORD_W-1:0] shreg;
    logic [BW-1:0]     bitcnt;
    logic              half;
    logic [GW-1:0]     gcnt;
    logic              word_end, can_start;
    logic [WORD_W-1:0] loaded;

    // Apply the parity rule to the most significant sent bit.
    function automatic logic [WORD_W-1:0] fmt(input logic [WORD_W-1:0] w,
                                               input logic par, input logic odd);
        logic p;
        p = odd ? ~(^w[WORD_W-2:0]) : ^w[WORD_W-2:0];
        return par ? {p, w[WORD_W-2:0]} : w;
    endfunction

    assign loaded    = fmt(fifo_head, ctrl.par, ctrl.odd);
    assign word_end  = (state == S_SEND) && half && (bitcnt == BW'(WORD_W - 1));
    assign can_start = (state == S_IDLE) || (word_end && ctrl.gap == '0) ||
                       (state == S_GAP && gcnt == GW'(1));
    assign pop       = ctrl.en && half_tick && can_start && !fifo_empty;
    assign drained   = ctrl.en && half_tick && word_end && fifo_empty;

    // Line sequencing: load, active half, null half, gap, or abort on disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            shreg   <= '0;
            bitcnt  <= '0;
            half    <= 1'b0;
            gcnt    <= '0;
            line_hi <= 1'b0;
            line_lo <= 1'b0;
        end else if (!ctrl.en) begin
            state   <= S_IDLE;
            line_hi <= 1'b0;
            line_lo <= 1'b0;
        end else if (half_tick) begin
            if (pop) begin
                state   <= S_SEND;
                shreg   <= loaded;
                bitcnt  <= '0;
                half    <= 1'b0;
                line_hi <= loaded[0];
                line_lo <= ~loaded[0];
            end else if (state == S_SEND) begin
                if (!half) begin
                    half    <= 1'b1;
                    line_hi <= 1'b0;
                    line_lo <= 1'b0;
                end else if (word_end) begin
                    state <= (ctrl.gap == '0) ? S_IDLE : S_GAP;
                    gcnt  <= {ctrl.gap, 1'b0};
                end else begin
                    bitcnt  <= bitcnt + 1'b1;
                    half    <= 1'b0;
                    shreg   <= shreg >> 1;
                    line_hi <= shreg[1];
                    line_lo <= ~shreg[1];
                end
            end else if (state == S_GAP) begin
                if (gcnt == GW'(1))
                    state <= S_IDLE;
                else
                    gcnt <= gcnt - 1'b1;
            end
        end
    end

    // End-of-transmission flag: set on a drained word end, cleared on a start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            eot <= 1'b1;
        else if (pop)
            eot <= 1'b0;
        else if (drained)
            eot <= 1'b1;
    end

    // R4: the two line wires are never driven together.
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_hi && line_lo));
    // R7: a disabled channel keeps the line null.
    a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |=> (!line_hi && !line_lo));
    // R11: the flag only rises when the queue was empty.
    a_r11_eot_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eot) |-> $past(fifo_empty));
    // R11: the flag only falls as a word begins on the line.
    a_r11_eot_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eot) |-> (line_hi || line_lo));
endmodule

// File: rtl/a429_tx_chan.sv
// Top of one transmit channel: register port, word queue and serializer.
// Assumes DEPTH <= 15 so free space fits the 4-bit read-back field.
module a429_tx_chan
    import a429_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        half_tick,
    output logic        line_hi,
    output logic        line_lo,
    output logic        eot,
    output logic        bad_wr
);
    localparam int CW     = $clog2(DEPTH + 1);
    localparam int WORD_W = 32;

    ctrl_t             ctrl;
    logic              flush, push, pop, drained;
    logic [WORD_W-1:0] push_word, head;
    logic [CW-1:0]     count;
    logic [3:0]        free;

    a429_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .drained(drained), .ctrl(ctrl), .flush(flush), .push(push),
        .push_word(push_word), .bad_wr(bad_wr)
    );

    a429_word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_word), .pop(pop),
        .flush(flush), .head(head), .count(count)
    );

    a429_serializer #(.WORD_W(WORD_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .ctrl(ctrl),
        .fifo_empty(count == '0), .fifo_head(head), .pop(pop), .drained(drained),
        .line_hi(line_hi), .line_lo(line_lo), .eot(eot)
    );

    // Free space for the read-back nibble.
    assign free = 4'(DEPTH - int'(count));

    // Read mux: only the control address returns data.
    always_comb begin
        if (addr == ADDR_CTRL)
            rd_data = {ctrl.en, 3'b000, ctrl.odd, ctrl.par, ctrl.gap, ctrl.fifo_on, free};
        else
            rd_data = '0;
    end
endmodule

// File: tb/sim_a429_tx_chan.sv
`timescale 1ns/1ps
module sim_a429_tx_chan;
    localparam int TDIV  = 4;
    localparam int DEPTH = 8;
    localparam logic [15:0] EN  = 16'h8000;
    localparam logic [15:0] FON = 16'h0010;

    logic clk = 0, rst_n = 0, wr_en = 0, half_tick = 0;
    logic [1:0]  addr = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] rd_data;
    logic line_hi, line_lo, eot, bad_wr;

    always #2.5 clk = ~clk;

    a429_tx_chan #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .half_tick(half_tick), .line_hi(line_hi),
        .line_lo(line_lo), .eot(eot), .bad_wr(bad_wr)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit tick_on = 0;
    int tcnt = 0;
    logic [15:0] cfg = 0;

    // monitor state
    logic [31:0] rx_word [64];
    int rx_first [64];
    int rx_last [64];
    int rx_n = 0, bitn = 0, npulse = 0, timing_err = 0, width = 0, first_c = 0, last_c = 0;
    logic [31:0] acc = 0;
    bit prev_act = 0;
    logic [31:0] exp_q [64];
    int exp_n = 0;

    always @(posedge clk) cyc++;

    // half-bit strobe generator
    always @(negedge clk) begin
        tcnt = (tcnt + 1) % TDIV;
        half_tick = tick_on && (tcnt == 0);
    end

    // line decoder
    always @(negedge clk) begin
        if (line_hi && line_lo) timing_err++;
        if ((line_hi || line_lo) && !prev_act) begin
            npulse++;
            if (bitn == 0) first_c = cyc;
            else if (cyc - last_c != 2 * TDIV) timing_err++;
            last_c = cyc;
            acc[bitn] = line_hi;
            width = 1;
            bitn++;
            if (bitn == 32) begin
                rx_word[rx_n] = acc; rx_first[rx_n] = first_c; rx_last[rx_n] = cyc;
                rx_n++; bitn = 0;
            end
        end else if (line_hi || line_lo) width++;
        else if (prev_act && width != TDIV) timing_err++;
        prev_act = line_hi || line_lo;
    end

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] fmt(logic [31:0] w, logic [15:0] c);
        logic p;
        p = c[11] ? ~(^w[30:0]) : ^w[30:0];
        return c[10] ? {p, w[30:0]} : w;
    endfunction

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk); wr_en = 1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 0; addr = 0;
    endtask

    task automatic rd(output logic [15:0] v);
        addr = 0; #1 v = rd_data;
    endtask

    task automatic push_word(logic [31:0] w, bit expect_it);
        wr(1, w[31:16]); wr(2, w[15:0]);
        if (expect_it) begin exp_q[exp_n] = fmt(w, cfg); exp_n++; end
    endtask

    task automatic arm();
        wr(0, cfg | FON); wr(0, cfg | FON | EN);
    endtask

    task automatic drain(int n);
        while (rx_n < n || eot !== 1'b1) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic mon_clear();
        bitn = 0; timing_err = 0; width = 0;
    endtask

    // compare a burst and its gaps; G from cfg
    task automatic check_burst(int base, string req);
        int g;
        g = int'(cfg[9:5]);
        for (int k = base; k < rx_n; k++) begin
            chk(rx_word[k] == exp_q[k], req, "received word", rx_word[k], exp_q[k]);
            if (k > base)
                chk(rx_first[k] - rx_last[k-1] == 2 * TDIV * (g + 1), "R6", "inter-word spacing",
                    rx_first[k] - rx_last[k-1], 2 * TDIV * (g + 1));
        end
        chk(timing_err == 0, "R4", "bit timing errors", timing_err, 0);
        timing_err = 0;
    endtask

    task automatic burst(int n, logic [15:0] c, string req);
        int base;
        cfg = c;
        base = rx_n;
        arm();
        for (int i = 0; i < n; i++) push_word($urandom, 1);
        drain(base + n);
        check_burst(base, req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int base, p0;
        logic [31:0] w;
        void'($urandom(1234));
        repeat (6) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd(v); chk(v == 16'h0008, "R1", "reset control read", v, 16'h0008);
        chk(eot == 1'b1, "R1", "reset eot", eot, 1);
        chk(!line_hi && !line_lo, "R1", "reset line null", {line_hi, line_lo}, 0);
        wr(0, 16'h700F); rd(v);
        chk(v == 16'h0008, "R1", "unwritable bits", v, 16'h0008);
        addr = 3; #1 chk(rd_data == 0, "R1", "address 3 read", rd_data, 0);

        tick_on = 1;
        // R2/R4/R11: plain words, no parity, no gap
        cfg = 0; base = rx_n; p0 = npulse;
        arm();
        for (int i = 0; i < 3; i++) push_word($urandom, 1);
        while (npulse == p0) @(negedge clk);
        chk(eot == 1'b0, "R11", "eot low while sending", eot, 0);
        drain(base + 3);
        chk(eot == 1'b1, "R11", "eot high after drain", eot, 1);
        check_burst(base, "R2");

        // R5 even parity, R6 gap 3
        burst(4, 16'h0400 | (16'd3 << 5), "R5");
        // R5 odd parity, R6 gap 31
        burst(2, 16'h0C00 | (16'd31 << 5), "R5");
        // R5 directed: all-zero word with odd parity gets bit 32 set
        cfg = 16'h0C00; base = rx_n; arm(); push_word(32'h0, 1); drain(base + 1);
        chk(rx_word[base] == 32'h8000_0000, "R5", "odd parity on zero word", rx_word[base], 32'h8000_0000);

        // R10: drained channel refuses writes until re-armed
        p0 = npulse;
        push_word(32'hA5A5_0001, 0);
        rd(v); chk(v[3:0] == 4'd8, "R10", "free after refused push", v[3:0], 8);
        repeat (400) @(negedge clk);
        chk(npulse == p0, "R10", "no pulses from refused word", npulse, p0);

        // R3: full queue drops the extra word
        cfg = 0; tick_on = 0; base = rx_n;
        arm();
        for (int i = 0; i < DEPTH; i++) push_word($urandom, 1);
        rd(v); chk(v[3:0] == 4'd0, "R3", "free when full", v[3:0], 0);
        push_word(32'hDEAD_BEEF, 0);
        rd(v); chk(v[3:0] == 4'd0, "R3", "free after dropped push", v[3:0], 0);
        tick_on = 1;
        drain(base + DEPTH);
        repeat (700) @(negedge clk);
        chk(rx_n == base + DEPTH, "R3", "words sent from full queue", rx_n, base + DEPTH);
        check_burst(base, "R3");

        // R8: flush and refused writes with queue bit low
        tick_on = 0; base = rx_n;
        arm();
        for (int i = 0; i < 3; i++) push_word($urandom, 0);
        rd(v); chk(v[3:0] == 4'd5, "R3", "free after three pushes", v[3:0], 5);
        wr(0, cfg | EN);
        rd(v); chk(v[3:0] == 4'd8, "R8", "free after flush", v[3:0], 8);
        push_word(32'h1234_5678, 0);
        rd(v); chk(v[3:0] == 4'd8, "R8", "push refused with queue bit low", v[3:0], 8);
        wr(0, cfg | EN | FON);
        w = $urandom;
        push_word(w, 1);
        rd(v); chk(v[3:0] == 4'd7, "R8", "push accepted after queue bit set", v[3:0], 7);
        tick_on = 1;
        drain(base + 1);
        repeat (300) @(negedge clk);
        chk(rx_n == base + 1, "R8", "only post-flush word sent", rx_n, base + 1);
        chk(rx_word[base] == w, "R8", "post-flush word", rx_word[base], w);

        // R9: forbidden double clear
        wr(0, cfg);
        chk(bad_wr == 1'b1, "R9", "bad_wr pulse", bad_wr, 1);
        rd(v); chk(v == (cfg | EN | FON | 16'h0008), "R9", "control unchanged", v, cfg | EN | FON | 16'h0008);
        @(negedge clk);
        chk(bad_wr == 1'b0, "R9", "bad_wr one cycle", bad_wr, 0);

        // R7: abort mid-word
        arm();
        push_word($urandom, 0); push_word($urandom, 0);
        while (bitn < 10) @(negedge clk);
        wr(0, cfg | FON);
        @(negedge clk);
        chk(!line_hi && !line_lo, "R7", "line null after abort", {line_hi, line_lo}, 0);
        mon_clear(); p0 = npulse;
        repeat (400) @(negedge clk);
        chk(npulse == p0, "R7", "no pulses while disabled", npulse, p0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule